// File: doc/BRIEF.md
# Interrupt Request Status Register

This block gathers the raw interrupt request lines of a small microcontroller into one 16-bit status word. Both the interrupt controller and software read this word. A mode input selects one of two layouts. In master layout the word shows the two serial ports, the external interrupt lines, the merged DMA/external requests and a single OR of all timers. In slave layout the word shows each timer on its own bit, together with a DMA halt control flag.

The DMA halt flag is the only stored state. A non-maskable interrupt event sets it. An interrupt-return event clears it. In slave layout, software may also write it directly. It drives the `dma_halt` output for as long as it is 1. All request bits follow their input lines and are never latched. The word is captured on each clock edge for readback. A request therefore disappears from the word one cycle after its source drops it.

Top module: `irq_status_reg`

## Requirements
- R1: After reset, `rd_data` reads 0x0000 and `dma_halt` is 0.
- R2: With `mode_slave`=1, `rd_data[2:0]` equals the `tmr_req[2:0]` lines of the previous cycle. Bits 14..3 read 0 whatever the other request inputs carry. Bit 15 reads the halt flag as it stood in the previous cycle.
- R3: With `mode_slave`=0, `rd_data[0]` is the OR of all three timer lines of the previous cycle. Bits 15..11 and bit 1 read 0.
- R4: With `mode_slave`=0, bit 10 is the OR of the seven sources of serial port 0 (`ser_src[6:0]`), gated by `ser_en[0]`. Bit 9 is the same for port 1 (`ser_src[13:7]`, `ser_en[1]`). A disabled port reads 0.
- R5: With `mode_slave`=0, bits 8..4 equal `ext_req[4:0]`. Bit 3 is `dma_req[1]` OR `ext_req[6]`. Bit 2 is `dma_req[0]` OR `ext_req[5]`.
- R6: A cycle with `nmi_evt`=1 sets the halt flag at the next edge. `dma_halt` always shows the flag.
- R7: A cycle with `iret_evt`=1 and `nmi_evt`=0 clears the halt flag at the next edge.
- R8: In slave mode, a cycle with `wr_en`=1 and no event loads `wr_data[15]` into the halt flag. The other written bits have no effect on the word.
- R9: In master mode, a write changes neither the halt flag nor the word.
- R10: When NMI and IRET coincide, NMI wins. A write in the same cycle as either event loses to the event.
- R11: Requests are not latched. A line that drops is gone from the word one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_slave | input | 1 | 1 selects slave layout, 0 master layout |
| tmr_req | input | 3 | Timer request lines |
| ext_req | input | 7 | External interrupt request lines 0..6 |
| dma_req | input | 2 | DMA channel request lines |
| ser_src | input | 14 | Serial port sources, 7 per port, port 0 in the low bits |
| ser_en | input | 2 | Per-port serial request enable |
| nmi_evt | input | 1 | Non-maskable interrupt event pulse |
| iret_evt | input | 1 | Interrupt-return event pulse |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write data |
| rd_data | output | 16 | Captured status word |
| dma_halt | output | 1 | DMA halt flag |

## Verification
Three things can update the halt flag in the same cycle: the hardware events and a software write. The bench raises NMI and IRET together, IRET together with a write of 1, and NMI together with a write of 0. It then checks that the flag follows the event and never the write. Each case is judged on `dma_halt` one edge later, and on bit 15 of the slave word one edge after that.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
   localparam int unsigned WORD_W    = 16;
   localparam int unsigned TMR_CNT   = 3;
   localparam int unsigned EXT_CNT   = 7;
   localparam int unsigned DMA_CNT   = 2;
   localparam int unsigned SER_PORTS = 2;
   localparam int unsigned SER_SRCS  = 7;

   // bit positions decoded by the interrupt controller
   localparam int unsigned POS_HALT  = 15;
   localparam int unsigned POS_SER0  = 10;
   localparam int unsigned POS_SER1  = 9;
   localparam int unsigned POS_EXT_LO = 4;
   localparam int unsigned POS_DMA1  = 3;
   localparam int unsigned POS_DMA0  = 2;
   localparam int unsigned POS_TMR   = 0;

   typedef enum logic {
      LAYOUT_MASTER = 1'b0,
      LAYOUT_SLAVE  = 1'b1
   } layout_e;
endpackage

// File: rtl/irq_halt_flag.sv
module irq_halt_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_evt,
   input  logic clr_evt,
   input  logic sw_wr,
   input  logic sw_val,
   output logic flag_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)       flag_q <= 1'b0;
      else if (set_evt) flag_q <= 1'b1;
      else if (clr_evt) flag_q <= 1'b0;
      else if (sw_wr)   flag_q <= sw_val;
   end

   AST_NMI_SETS_HALT: assert property (@(posedge clk) disable iff (!rst_n)
      set_evt |=> flag_q); // R6
   AST_IRET_CLEARS_HALT: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_evt && !set_evt) |=> !flag_q); // R7
   AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_evt && !clr_evt && !sw_wr) |=> $stable(flag_q)); // R9
endmodule

// File: rtl/irq_serial_merge.sv
module irq_serial_merge #(
   parameter int unsigned PORTS = 2,
   parameter int unsigned SRCS  = 7,
   localparam int unsigned SRC_W = PORTS * SRCS
) (
   input  logic [SRC_W-1:0] src,
   input  logic [PORTS-1:0] en,
   output logic [PORTS-1:0] req
);
   if (PORTS < 1 || SRCS < 1) begin : g_bad_cfg
      $error("irq_serial_merge: PORTS and SRCS must be at least 1");
   end

   for (genvar p = 0; p < PORTS; p++) begin : g_port
      assign req[p] = en[p] & (|src[p*SRCS +: SRCS]);
   end
endmodule

// File: rtl/irq_word_build.sv
module irq_word_build
   import irq_status_pkg::*;
#(
   parameter int unsigned W    = WORD_W,
   parameter int unsigned NTMR = TMR_CNT,
   parameter int unsigned NEXT = EXT_CNT,
   parameter int unsigned NDMA = DMA_CNT,
   parameter int unsigned NSER = SER_PORTS
) (
   input  layout_e          layout,
   input  logic [NTMR-1:0]  tmr,
   input  logic [NEXT-1:0]  ext,
   input  logic [NDMA-1:0]  dma,
   input  logic [NSER-1:0]  ser,
   input  logic             halt,
   output logic [W-1:0]     word
);
   always_comb begin
      word = '0;
      if (layout == LAYOUT_SLAVE) begin
         word[POS_HALT]            = halt;
         word[POS_TMR +: NTMR]     = tmr;
      end else begin
         word[POS_TMR]             = |tmr;
         word[POS_DMA0]            = dma[0] | ext[5];
         word[POS_DMA1]            = dma[1] | ext[6];
         word[POS_EXT_LO +: 5]     = ext[4:0];
         word[POS_SER1]            = ser[1];
         word[POS_SER0]            = ser[0];
      end
   end
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
   import irq_status_pkg::*;
#(
   parameter int unsigned DATA_W   = WORD_W,
   parameter int unsigned NUM_TMR  = TMR_CNT,
   parameter int unsigned NUM_EXT  = EXT_CNT,
   parameter int unsigned NUM_DMA  = DMA_CNT,
   parameter int unsigned NUM_SER  = SER_PORTS,
   parameter int unsigned SER_SRC  = SER_SRCS,
   parameter bit          REG_READ = 1'b1,
   localparam int unsigned SER_W   = NUM_SER * SER_SRC
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_slave,
   input  logic [NUM_TMR-1:0] tmr_req,
   input  logic [NUM_EXT-1:0] ext_req,
   input  logic [NUM_DMA-1:0] dma_req,
   input  logic [SER_W-1:0]  ser_src,
   input  logic [NUM_SER-1:0] ser_en,
   input  logic              nmi_evt,
   input  logic              iret_evt,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              dma_halt
);
   if (DATA_W != 16)  begin : g_bad_w   $error("irq_status_reg: DATA_W must be 16");  end
   if (NUM_TMR != 3)  begin : g_bad_tmr $error("irq_status_reg: NUM_TMR must be 3");  end
   if (NUM_EXT != 7)  begin : g_bad_ext $error("irq_status_reg: NUM_EXT must be 7");  end
   if (NUM_DMA != 2)  begin : g_bad_dma $error("irq_status_reg: NUM_DMA must be 2");  end
   if (NUM_SER != 2)  begin : g_bad_ser $error("irq_status_reg: NUM_SER must be 2");  end

   layout_e            layout;
   logic [NUM_SER-1:0] ser_req;
   logic               halt_q;
   logic [DATA_W-1:0]  word_nxt;
   logic               unused_wr_low;

   assign layout        = mode_slave ? LAYOUT_SLAVE : LAYOUT_MASTER;
   assign unused_wr_low = ^wr_data[DATA_W-2:0];

   irq_serial_merge #(.PORTS(NUM_SER), .SRCS(SER_SRC)) u_ser (
      .src (ser_src),
      .en  (ser_en),
      .req (ser_req)
   );

   irq_halt_flag u_halt (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_evt (nmi_evt),
      .clr_evt (iret_evt),
      .sw_wr   (wr_en && layout == LAYOUT_SLAVE),
      .sw_val  (wr_data[POS_HALT]),
      .flag_q  (halt_q)
   );

   irq_word_build #(
      .W(DATA_W), .NTMR(NUM_TMR), .NEXT(NUM_EXT), .NDMA(NUM_DMA), .NSER(NUM_SER)
   ) u_build (
      .layout (layout),
      .tmr    (tmr_req),
      .ext    (ext_req),
      .dma    (dma_req),
      .ser    (ser_req),
      .halt   (halt_q),
      .word   (word_nxt)
   );

   assign dma_halt = halt_q;

   if (REG_READ) begin : g_reg_read
      always_ff @(posedge clk) begin
         if (!rst_n) rd_data <= '0;
         else        rd_data <= word_nxt;
      end

      AST_MASTER_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         !mode_slave |=> (rd_data[15:11] == 5'd0 && !rd_data[1])); // R3
      AST_SLAVE_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         mode_slave |=> (rd_data[14:3] == 12'd0)); // R2
      AST_SLAVE_TMR_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
         mode_slave |=> (rd_data[2:0] == $past(tmr_req))); // R11
   end else begin : g_comb_read
      assign rd_data = word_nxt;
   end
endmodule

// File: tb/irq_status_reg_bench.sv
`timescale 1ns/1ps
module irq_status_reg_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_slave = 1'b0;
   logic [2:0]  tmr_req = '0;
   logic [6:0]  ext_req = '0;
   logic [1:0]  dma_req = '0;
   logic [13:0] ser_src = '0;
   logic [1:0]  ser_en = '0;
   logic        nmi_evt = 1'b0;
   logic        iret_evt = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;
   logic        dma_halt;

   irq_status_reg u_irq_status_reg (
      .clk(clk), .rst_n(rst_n), .mode_slave(mode_slave), .tmr_req(tmr_req),
      .ext_req(ext_req), .dma_req(dma_req), .ser_src(ser_src), .ser_en(ser_en),
      .nmi_evt(nmi_evt), .iret_evt(iret_evt), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .dma_halt(dma_halt)
   );

   always #2.5 clk = ~clk;

   typedef struct {
      int          due;
      logic [15:0] rd;
      logic        halt;
   } exp_t;

   exp_t  exp_q[$];
   string tag_q[$];
   int    cyc = 0;
   int    checks = 0;
   int    errors = 0;
   logic  halt_m = 1'b0;
   bit    done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   // expected word computed from the requirement text
   function automatic logic [15:0] model_word(logic halt);
      logic [15:0] w = '0;
      if (mode_slave) begin
         w[15]  = halt;       // R2
         w[2:0] = tmr_req;
      end else begin
         w[0]   = |tmr_req;   // R3
         w[10]  = ser_en[0] & (|ser_src[6:0]);   // R4
         w[9]   = ser_en[1] & (|ser_src[13:7]);
         w[8:4] = ext_req[4:0];                  // R5
         w[3]   = dma_req[1] | ext_req[6];
         w[2]   = dma_req[0] | ext_req[5];
      end
      return w;
   endfunction

   // driver: push expectation, advance one cycle, drop pulses
   task automatic step(input string tag);
      exp_t  e;
      logic  nxt;
      if (nmi_evt)                 nxt = 1'b1;   // R6, R10
      else if (iret_evt)           nxt = 1'b0;   // R7
      else if (wr_en && mode_slave) nxt = wr_data[15]; // R8
      else                         nxt = halt_m; // R9
      e.due  = cyc + 1;
      e.rd   = model_word(halt_m);
      e.halt = nxt;
      exp_q.push_back(e);
      tag_q.push_back(tag);
      halt_m = nxt;
      @(posedge clk);
      @(negedge clk);
      nmi_evt  = 1'b0;
      iret_evt = 1'b0;
      wr_en    = 1'b0;
      wr_data  = '0;
   endtask

   // monitor: pop and compare when due
   always @(negedge clk) begin
      exp_t  e;
      string t;
      while (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         checks++;
         if (rd_data !== e.rd || dma_halt !== e.halt) begin
            errors++;
            $display("FAIL %s rd_data=%h halt=%b expected rd_data=%h halt=%b",
                     t, rd_data, dma_halt, e.rd, e.halt);
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog (all requirements) actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      checks++;   // R1 reset state
      if (rd_data !== 16'h0000 || dma_halt !== 1'b0) begin
         errors++;
         $display("FAIL R1 rd_data=%h halt=%b expected rd_data=0000 halt=0", rd_data, dma_halt);
      end
      rst_n = 1'b1;
      step("R1 idle after reset");

      // slave layout: per-timer bits, other requests ignored
      mode_slave = 1'b1;
      tmr_req = 3'b101;                              step("R2 timers 101");
      tmr_req = 3'b010;                              step("R2 timers 010");
      ext_req = 7'h7F; dma_req = 2'b11; ser_src = '1; ser_en = 2'b11;
                                                     step("R2 others ignored");
      ext_req = '0; dma_req = '0; ser_src = '0; ser_en = '0;
      tmr_req = 3'b000;                              step("R11 timers dropped");

      // master layout
      mode_slave = 1'b0;
      tmr_req = 3'b100;                              step("R3 timer OR");
      tmr_req = 3'b000;                              step("R11 timer OR cleared");
      ser_src = 14'h0008; ser_en = 2'b01;            step("R4 port0 enabled");
      ser_en = 2'b00;                                step("R4 port0 disabled");
      ser_src = 14'h2000; ser_en = 2'b10;            step("R4 port1 enabled");
      ser_src = '0; ser_en = '0;
      ext_req = 7'h1F;                               step("R5 ext 4..0");
      ext_req = 7'h20;                               step("R5 ext5 into bit2");
      ext_req = '0; dma_req = 2'b10;                 step("R5 dma1 into bit3");
      dma_req = 2'b01; ext_req = 7'h40;              step("R5 dma0 and ext6");
      dma_req = '0; ext_req = '0;                    step("R11 idle master");

      // halt flag
      nmi_evt = 1'b1;                                step("R6 nmi sets halt");
      mode_slave = 1'b1;                             step("R6 slave shows halt");
      iret_evt = 1'b1;                               step("R7 iret clears halt");
      step("R7 slave shows cleared");
      wr_en = 1'b1; wr_data = 16'h8000;              step("R8 write sets halt");
      wr_en = 1'b1; wr_data = 16'h7FFF;              step("R8 write clears halt");
      step("R8 low write bits ignored");
      mode_slave = 1'b0;
      wr_en = 1'b1; wr_data = 16'hFFFF;              step("R9 master write ignored");
      step("R9 master word unchanged");

      // collisions
      mode_slave = 1'b1;
      nmi_evt = 1'b1; iret_evt = 1'b1;               step("R10 nmi beats iret");
      iret_evt = 1'b1; wr_en = 1'b1; wr_data = 16'h8000; step("R10 iret beats write");
      nmi_evt = 1'b1; wr_en = 1'b1; wr_data = 16'h0000;  step("R10 nmi beats write");
      step("R10 slave shows halt");
      step("R10 settle");

      repeat (2) @(negedge clk);
      done = 1'b1;
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL scoreboard (all requirements) pending=%0d expected=0", exp_q.size());
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule